// File: doc/BRIEF.md
# Dispatch Resource Gate

This block sits at the head of an in-order dispatch stage of a superscalar core. Each cycle it looks at a group of up to `SLOTS` decoded instructions. Each slot has an execution-unit class, an operation code and destination descriptors. The block also sees the free counts of the reorder buffer and of four rename pools: general registers, condition-register fields, the link register and the count register. From these it computes how many leading instructions of the group may dispatch, and how many entries of each pool those instructions take.

Slots are examined strictly in program order. A slot's demand is added to the running demand of the slots before it. The group ends at the first slot that is empty or whose demand no longer fits.

Two operations serialise the pipeline: a condition-register move that writes all fields, and a system call. Such an operation dispatches itself and then closes the group. It also raises an interlock request. A register captures that request and suppresses all further dispatch until a clear pulse arrives.

Top module: `dsp_gate`

## Requirements
- R1: The dispatch count equals the index of the first slot whose demand, added to the demand of all earlier dispatched slots, exceeds a free count. No later slot is dispatched, even one whose own demand would fit.
- R2: Unit codes 0 and 3 (general) and 2 (system register) need one reorder-buffer entry per slot. Unit code 1 (branch) needs one only when it writes the link or count register.
- R3: A system-register slot with op 0 (move to special register) needs one link buffer when its special-register number is 8, one count buffer when it is 9, and no rename buffer otherwise.
- R4: System-register ops 1 (move from special register) and 2 (move from time base) need one general rename buffer only when the slot's destination-valid bit is 1.
- R5: System-register ops 3 (condition logical), 5 (condition-field move) and op 4 (move to condition fields) with the all-fields bit at 0 each need one condition rename buffer.
- R6: System-register op 4 with the all-fields bit at 1, and op 6 (system call), dispatch if their reorder-buffer entry fits. The count is then that slot's index plus one, and `intlk_req` is 1. Op 7 needs only a reorder-buffer entry.
- R7: A branch slot needs one count buffer when its count-write bit is 1 and one link buffer when its link-write bit is 1. A shortage stops dispatch at that branch.
- R8: Pool use is cumulative within a cycle: two slots needing the same pool both dispatch only if the free count is at least two.
- R9: Each `use_*` output equals the total demand of the dispatched slots only. It never includes the blocking slot and never exceeds the matching free count.
- R10: `intlk_hold` is 0 after reset. It becomes 1 on the edge after `intlk_req` is 1 and stays 1 until an edge with `intlk_clr` at 1. While it is 1, the count, all `use_*` outputs and `intlk_req` are 0.
- R11: A slot whose valid bit is 0 ends the group. Slot i occupies bits [i*W +: W] of every per-slot port, where W is that port's per-slot width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_vld | input | SLOTS | Slot holds an instruction |
| slot_unit | input | 2*SLOTS | Execution-unit class per slot |
| slot_op | input | 3*SLOTS | System-register operation code per slot |
| slot_spr | input | SPR_W*SLOTS | Special-register number per slot |
| slot_dst_ok | input | SLOTS | Destination register index is valid |
| slot_allf | input | SLOTS | Condition move targets all fields |
| slot_br_ctr | input | SLOTS | Branch writes the count register |
| slot_br_lnk | input | SLOTS | Branch writes the link register |
| free_rob | input | CNT_W | Free reorder-buffer entries |
| free_gpr | input | CNT_W | Free general rename buffers |
| free_cr | input | CNT_W | Free condition rename buffers |
| free_lnk | input | CNT_W | Free link rename buffers |
| free_ctr | input | CNT_W | Free count rename buffers |
| intlk_clr | input | 1 | Clears the held interlock |
| disp_cnt | output | CW | Number of leading slots dispatched |
| use_rob | output | CW | Reorder-buffer entries taken |
| use_gpr | output | CW | General rename buffers taken |
| use_cr | output | CW | Condition rename buffers taken |
| use_lnk | output | CW | Link rename buffers taken |
| use_ctr | output | CW | Count rename buffers taken |
| intlk_req | output | 1 | This group ends in a serialising operation |
| intlk_hold | output | 1 | Interlock held; dispatch suppressed |

## Verification
The assertions assume that the free counts and slot fields are settled before each rising edge. They also assume that `intlk_clr` is sampled only at edges, so the held flag changes only there. The stimulus changes all inputs at falling edges only. Free counts are mostly kept between 0 and 3, so that exhaustion, exact fit and cumulative shortage all occur often. Clear pulses arrive both while the interlock is held and while it is idle.

// File: rtl/dsp_pkg.sv
`timescale 1ns/1ps
package dsp_pkg;
   typedef enum logic [1:0] {
      U_GEN = 2'd0,
      U_BRN = 2'd1,
      U_SYS = 2'd2,
      U_ALT = 2'd3
   } unit_e;

   typedef enum logic [2:0] {
      OP_TO_SPR   = 3'd0,
      OP_FROM_SPR = 3'd1,
      OP_FROM_TB  = 3'd2,
      OP_CR_LOGIC = 3'd3,
      OP_TO_CRF   = 3'd4,
      OP_CRF_MOVE = 3'd5,
      OP_SYSCALL  = 3'd6,
      OP_PLAIN    = 3'd7
   } sysop_e;

   typedef struct packed {
      logic rob;
      logic gpr;
      logic cr;
      logic lnk;
      logic ctr;
      logic ser;
   } need_t;
endpackage

// File: rtl/dsp_slot_need.sv
`timescale 1ns/1ps
module dsp_slot_need
   import dsp_pkg::*;
#(
   parameter int SPR_W   = 10,
   parameter int LNK_SPR = 8,
   parameter int CTR_SPR = 9
) (
   input  logic [1:0]       unit,
   input  logic [2:0]       op,
   input  logic [SPR_W-1:0] spr,
   input  logic             dst_ok,
   input  logic             allf,
   input  logic             br_ctr,
   input  logic             br_lnk,
   output need_t            nd
);
   always_comb begin
      nd = '0;
      unique case (unit_e'(unit))
         U_BRN: begin
            nd.rob = br_ctr | br_lnk;
            nd.ctr = br_ctr;
            nd.lnk = br_lnk;
         end
         U_SYS: begin
            nd.rob = 1'b1;
            unique case (sysop_e'(op))
               OP_TO_SPR: begin
                  nd.lnk = (spr == SPR_W'(LNK_SPR));
                  nd.ctr = (spr == SPR_W'(CTR_SPR));
               end
               OP_FROM_SPR, OP_FROM_TB: nd.gpr = dst_ok;
               OP_CR_LOGIC, OP_CRF_MOVE: nd.cr = 1'b1;
               OP_TO_CRF: begin
                  nd.ser = allf;
                  nd.cr  = ~allf;
               end
               OP_SYSCALL: nd.ser = 1'b1;
               default: ;
            endcase
         end
         default: nd.rob = 1'b1;
      endcase
   end
endmodule

// File: rtl/dsp_prefix_gate.sv
`timescale 1ns/1ps
module dsp_prefix_gate
   import dsp_pkg::*;
#(
   parameter int SLOTS = 4,
   parameter int CNT_W = 4,
   parameter int CW    = 3
) (
   input  logic             en,
   input  logic [SLOTS-1:0] vld,
   input  need_t            nd [SLOTS],
   input  logic [CNT_W-1:0] free_rob,
   input  logic [CNT_W-1:0] free_gpr,
   input  logic [CNT_W-1:0] free_cr,
   input  logic [CNT_W-1:0] free_lnk,
   input  logic [CNT_W-1:0] free_ctr,
   output logic [CW-1:0]    cnt,
   output logic [CW-1:0]    u_rob,
   output logic [CW-1:0]    u_gpr,
   output logic [CW-1:0]    u_cr,
   output logic [CW-1:0]    u_lnk,
   output logic [CW-1:0]    u_ctr,
   output logic             ser_end
);
   localparam int AW = CNT_W + 1;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] acc, input logic b);
      return acc + {{(AW-1){1'b0}}, b};
   endfunction

   logic [AW-1:0] a_rob, a_gpr, a_cr, a_lnk, a_ctr;
   logic [AW-1:0] t_rob, t_gpr, t_cr, t_lnk, t_ctr;
   logic          run, fit;

   always_comb begin
      a_rob = '0; a_gpr = '0; a_cr = '0; a_lnk = '0; a_ctr = '0;
      t_rob = '0; t_gpr = '0; t_cr = '0; t_lnk = '0; t_ctr = '0;
      fit     = 1'b0;
      run     = en;
      cnt     = '0;
      ser_end = 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
         t_rob = bump(a_rob, nd[i].rob);
         t_gpr = bump(a_gpr, nd[i].gpr);
         t_cr  = bump(a_cr,  nd[i].cr);
         t_lnk = bump(a_lnk, nd[i].lnk);
         t_ctr = bump(a_ctr, nd[i].ctr);
         fit = run && vld[i]
            && (t_rob <= {1'b0, free_rob}) && (t_gpr <= {1'b0, free_gpr})
            && (t_cr  <= {1'b0, free_cr})  && (t_lnk <= {1'b0, free_lnk})
            && (t_ctr <= {1'b0, free_ctr});
         if (fit) begin
            a_rob = t_rob; a_gpr = t_gpr; a_cr = t_cr;
            a_lnk = t_lnk; a_ctr = t_ctr;
            cnt   = cnt + CW'(1);
            if (nd[i].ser) begin
               ser_end = 1'b1;
               run     = 1'b0;
            end
         end else begin
            run = 1'b0;
         end
      end
      u_rob = a_rob[CW-1:0];
      u_gpr = a_gpr[CW-1:0];
      u_cr  = a_cr[CW-1:0];
      u_lnk = a_lnk[CW-1:0];
      u_ctr = a_ctr[CW-1:0];
   end
endmodule

// File: rtl/dsp_intlk.sv
`timescale 1ns/1ps
module dsp_intlk (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic hold
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hold <= 1'b0;
      else if (set) hold <= 1'b1;
      else if (clr) hold <= 1'b0;
   end
endmodule

// File: rtl/dsp_gate.sv
`timescale 1ns/1ps
module dsp_gate
   import dsp_pkg::*;
#(
   parameter int SLOTS   = 4,
   parameter int CNT_W   = 4,
   parameter int SPR_W   = 10,
   parameter int LNK_SPR = 8,
   parameter int CTR_SPR = 9,
   localparam int CW     = $clog2(SLOTS + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SLOTS-1:0]       slot_vld,
   input  logic [2*SLOTS-1:0]     slot_unit,
   input  logic [3*SLOTS-1:0]     slot_op,
   input  logic [SPR_W*SLOTS-1:0] slot_spr,
   input  logic [SLOTS-1:0]       slot_dst_ok,
   input  logic [SLOTS-1:0]       slot_allf,
   input  logic [SLOTS-1:0]       slot_br_ctr,
   input  logic [SLOTS-1:0]       slot_br_lnk,
   input  logic [CNT_W-1:0]       free_rob,
   input  logic [CNT_W-1:0]       free_gpr,
   input  logic [CNT_W-1:0]       free_cr,
   input  logic [CNT_W-1:0]       free_lnk,
   input  logic [CNT_W-1:0]       free_ctr,
   input  logic                   intlk_clr,
   output logic [CW-1:0]          disp_cnt,
   output logic [CW-1:0]          use_rob,
   output logic [CW-1:0]          use_gpr,
   output logic [CW-1:0]          use_cr,
   output logic [CW-1:0]          use_lnk,
   output logic [CW-1:0]          use_ctr,
   output logic                   intlk_req,
   output logic                   intlk_hold
);
   if (SLOTS < 1) begin : g_bad_slots
      $error("dsp_gate: SLOTS must be at least 1");
   end
   if ((64'd1 << CNT_W) <= 64'(SLOTS)) begin : g_bad_cnt
      $error("dsp_gate: CNT_W too narrow for SLOTS");
   end
   if (LNK_SPR >= (1 << SPR_W) || CTR_SPR >= (1 << SPR_W) || LNK_SPR == CTR_SPR) begin : g_bad_spr
      $error("dsp_gate: special-register numbers out of range or equal");
   end

   need_t nd [SLOTS];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      dsp_slot_need #(
         .SPR_W  (SPR_W),
         .LNK_SPR(LNK_SPR),
         .CTR_SPR(CTR_SPR)
      ) u_need (
         .unit  (slot_unit[2*g +: 2]),
         .op    (slot_op[3*g +: 3]),
         .spr   (slot_spr[SPR_W*g +: SPR_W]),
         .dst_ok(slot_dst_ok[g]),
         .allf  (slot_allf[g]),
         .br_ctr(slot_br_ctr[g]),
         .br_lnk(slot_br_lnk[g]),
         .nd    (nd[g])
      );
   end

   dsp_prefix_gate #(
      .SLOTS(SLOTS),
      .CNT_W(CNT_W),
      .CW   (CW)
   ) u_gate (
      .en      (~intlk_hold),
      .vld     (slot_vld),
      .nd      (nd),
      .free_rob(free_rob),
      .free_gpr(free_gpr),
      .free_cr (free_cr),
      .free_lnk(free_lnk),
      .free_ctr(free_ctr),
      .cnt     (disp_cnt),
      .u_rob   (use_rob),
      .u_gpr   (use_gpr),
      .u_cr    (use_cr),
      .u_lnk   (use_lnk),
      .u_ctr   (use_ctr),
      .ser_end (intlk_req)
   );

   dsp_intlk u_intlk (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (intlk_req),
      .clr  (intlk_clr),
      .hold (intlk_hold)
   );
endmodule

// File: rtl/dsp_gate_chk.sv
`timescale 1ns/1ps
module dsp_gate_chk #(
   parameter int SLOTS = 4,
   parameter int CNT_W = 4,
   parameter int CW    = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] free_rob,
   input logic [CNT_W-1:0] free_gpr,
   input logic [CNT_W-1:0] free_cr,
   input logic [CNT_W-1:0] free_lnk,
   input logic [CNT_W-1:0] free_ctr,
   input logic             intlk_clr,
   input logic [CW-1:0]    disp_cnt,
   input logic [CW-1:0]    use_rob,
   input logic [CW-1:0]    use_gpr,
   input logic [CW-1:0]    use_cr,
   input logic [CW-1:0]    use_lnk,
   input logic [CW-1:0]    use_ctr,
   input logic             intlk_req,
   input logic             intlk_hold
);
   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(disp_cnt) <= SLOTS);
   // R2
   rob_per_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(use_rob) <= int'(disp_cnt));
   // R9
   use_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(use_rob) <= int'(free_rob) && int'(use_gpr) <= int'(free_gpr) &&
      int'(use_cr) <= int'(free_cr) && int'(use_lnk) <= int'(free_lnk) &&
      int'(use_ctr) <= int'(free_ctr));
   // R6
   req_has_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intlk_req |-> disp_cnt != '0);
   // R6
   req_sets_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intlk_req |=> intlk_hold);
   // R10
   hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      intlk_hold |-> (disp_cnt == '0 && use_rob == '0 && !intlk_req));
   // R10
   hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (intlk_hold && !intlk_clr) |=> intlk_hold);
   // R10
   clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (intlk_hold && intlk_clr) |=> !intlk_hold);
endmodule

bind dsp_gate dsp_gate_chk #(
   .SLOTS(SLOTS),
   .CNT_W(CNT_W),
   .CW   (CW)
) u_chk (.*);

// File: tb/tb_dsp_gate.sv
`timescale 1ns/1ps
module tb_dsp_gate;
   localparam int SLOTS = 4;
   localparam int CNT_W = 4;
   localparam int SPR_W = 10;
   localparam int CW    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [SLOTS-1:0]       slot_vld = '0;
   logic [2*SLOTS-1:0]     slot_unit = '0;
   logic [3*SLOTS-1:0]     slot_op = '0;
   logic [SPR_W*SLOTS-1:0] slot_spr = '0;
   logic [SLOTS-1:0]       slot_dst_ok = '0, slot_allf = '0, slot_br_ctr = '0, slot_br_lnk = '0;
   logic [CNT_W-1:0]       free_rob = '0, free_gpr = '0, free_cr = '0, free_lnk = '0, free_ctr = '0;
   logic                   intlk_clr = 1'b0;
   logic [CW-1:0]          disp_cnt, use_rob, use_gpr, use_cr, use_lnk, use_ctr;
   logic                   intlk_req, intlk_hold;

   always #10 clk = ~clk;

   dsp_gate dut (.*);

   int n_run = 0, n_bad = 0;
   int v[SLOTS], un[SLOTS], op[SLOTS], spr[SLOTS], dv[SLOTS], af[SLOTS], bc[SLOTS], bl[SLOTS];
   int fr[5];
   int m_hold = 0;

   task automatic chk(string tag, string what, int got, int exp);
      n_run++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic clear_slots();
      for (int i = 0; i < SLOTS; i++) begin
         v[i] = 0; un[i] = 0; op[i] = 7; spr[i] = 0;
         dv[i] = 0; af[i] = 0; bc[i] = 0; bl[i] = 0;
      end
   endtask

   // one cycle: drive at falling edge, compare, update model state at rising edge
   task automatic step(string tag, int clr);
      int e_cnt, e_req, run;
      int tot[5], nd[5];
      int ser, fits;
      @(negedge clk);
      for (int i = 0; i < SLOTS; i++) begin
         slot_vld[i] = v[i][0];
         slot_unit[2*i +: 2] = un[i][1:0];
         slot_op[3*i +: 3] = op[i][2:0];
         slot_spr[SPR_W*i +: SPR_W] = spr[i][SPR_W-1:0];
         slot_dst_ok[i] = dv[i][0]; slot_allf[i] = af[i][0];
         slot_br_ctr[i] = bc[i][0]; slot_br_lnk[i] = bl[i][0];
      end
      free_rob = fr[0][CNT_W-1:0]; free_gpr = fr[1][CNT_W-1:0]; free_cr = fr[2][CNT_W-1:0];
      free_lnk = fr[3][CNT_W-1:0]; free_ctr = fr[4][CNT_W-1:0];
      intlk_clr = clr[0];
      e_cnt = 0; e_req = 0; run = (m_hold == 0);
      for (int k = 0; k < 5; k++) tot[k] = 0;
      for (int i = 0; i < SLOTS && run != 0; i++) begin
         for (int k = 0; k < 5; k++) nd[k] = 0;
         ser = 0;
         if (un[i] == 1) begin
            nd[0] = (bc[i] | bl[i]); nd[4] = bc[i]; nd[3] = bl[i];
         end else if (un[i] == 2) begin
            nd[0] = 1;
            case (op[i])
               0: begin nd[3] = (spr[i] == 8); nd[4] = (spr[i] == 9); end
               1, 2: nd[1] = dv[i];
               3, 5: nd[2] = 1;
               4: if (af[i] != 0) ser = 1; else nd[2] = 1;
               6: ser = 1;
               default: ;
            endcase
         end else nd[0] = 1;
         fits = v[i];
         for (int k = 0; k < 5; k++) if (tot[k] + nd[k] > fr[k]) fits = 0;
         if (fits != 0) begin
            for (int k = 0; k < 5; k++) tot[k] += nd[k];
            e_cnt++;
            if (ser != 0) begin e_req = 1; run = 0; end
         end else run = 0;
      end
      #5;
      chk(tag, "disp_cnt (R1)", int'(disp_cnt), e_cnt);
      chk(tag, "use_rob (R2)", int'(use_rob), tot[0]);
      chk(tag, "use_gpr (R4)", int'(use_gpr), tot[1]);
      chk(tag, "use_cr (R5)", int'(use_cr), tot[2]);
      chk(tag, "use_lnk (R3)", int'(use_lnk), tot[3]);
      chk(tag, "use_ctr (R7)", int'(use_ctr), tot[4]);
      chk(tag, "intlk_req (R6)", int'(intlk_req), e_req);
      chk(tag, "intlk_hold (R10)", int'(intlk_hold), m_hold);
      @(posedge clk);
      if (e_req != 0) m_hold = 1;
      else if (clr != 0) m_hold = 0;
   endtask

   task automatic set_free(int a, int b, int c, int d, int e);
      fr[0] = a; fr[1] = b; fr[2] = c; fr[3] = d; fr[4] = e;
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      clear_slots();
      set_free(0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      chk("R10", "hold after reset", int'(intlk_hold), 0);
      rst_n = 1'b1;

      // R1 / R9: four general slots, only two reorder entries
      for (int i = 0; i < SLOTS; i++) v[i] = 1;
      set_free(2, 3, 3, 3, 3);
      step("R9", 0);
      // R1: blocked first slot stops later free ones
      un[0] = 2; op[0] = 3; set_free(4, 4, 0, 4, 4);
      step("R1", 0);
      // R3: move to special register 8 without link buffer
      clear_slots(); v[0] = 1; v[1] = 1; un[0] = 2; op[0] = 0; spr[0] = 8;
      set_free(4, 4, 4, 0, 4);
      step("R3", 0);
      spr[0] = 9; set_free(4, 4, 4, 4, 1);
      step("R3", 0);
      spr[0] = 12; set_free(4, 0, 0, 0, 0);
      step("R3", 0);
      // R4: invalid destination needs no general buffer
      un[0] = 2; op[0] = 1; dv[0] = 0; set_free(4, 0, 4, 4, 4);
      step("R4", 0);
      dv[0] = 1; op[0] = 2;
      step("R4", 0);
      // R5 / R8: two condition ops sharing one buffer
      clear_slots(); v[0] = 1; v[1] = 1; v[2] = 1;
      un[0] = 2; op[0] = 3; un[1] = 2; op[1] = 5; un[2] = 2; op[2] = 4;
      set_free(4, 4, 1, 4, 4);
      step("R8", 0);
      set_free(4, 4, 3, 4, 4);
      step("R5", 0);
      // R6: all-fields move ends the group and raises the interlock
      af[1] = 1; op[1] = 4;
      step("R6", 0);
      step("R10", 0);
      step("R10", 1);
      step("R10", 0);
      // R6: system call with no reorder entry does not dispatch
      clear_slots(); v[0] = 1; un[0] = 2; op[0] = 6; set_free(0, 4, 4, 4, 4);
      step("R6", 0);
      // R7: branch writing count register with empty pool
      clear_slots(); v[0] = 1; v[1] = 1; un[0] = 1; bc[0] = 1;
      set_free(4, 4, 4, 4, 0);
      step("R7", 0);
      bc[0] = 0; bl[0] = 1; set_free(1, 4, 4, 1, 0);
      step("R7", 0);
      bl[0] = 0; set_free(0, 0, 0, 0, 0);
      step("R2", 0);
      // R11: invalid slot ends the group
      clear_slots(); v[0] = 1; v[1] = 0; v[2] = 1; set_free(4, 4, 4, 4, 4);
      step("R11", 0);

      for (int n = 0; n < 3000; n++) begin
         for (int i = 0; i < SLOTS; i++) begin
            v[i] = ($urandom_range(0, 7) != 0) ? 1 : 0;
            un[i] = $urandom_range(0, 3);
            op[i] = $urandom_range(0, 7);
            case ($urandom_range(0, 2))
               0: spr[i] = 8;
               1: spr[i] = 9;
               default: spr[i] = $urandom_range(0, 1023);
            endcase
            dv[i] = $urandom_range(0, 1); af[i] = $urandom_range(0, 1);
            bc[i] = $urandom_range(0, 1); bl[i] = $urandom_range(0, 1);
         end
         for (int k = 0; k < 5; k++) fr[k] = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 15) : $urandom_range(0, 3);
         step("R8", ($urandom_range(0, 3) == 0) ? 1 : 0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule